// File: doc/BRIEF.md
# Direct-Mapped Instruction Cache

This block sits between a 32-bit CPU instruction fetch port and a word-wide instruction memory. The CPU presents a fetch address with a valid/ready handshake and gets back a 32-bit opcode. Fetches from two cacheable address segments, top byte 0x00 and 0x80, are looked up in a 4 KB direct-mapped array. A hit answers in the same cycle. A miss stalls the CPU while the whole 16-byte line is read one word at a time and written into the array. The requested word is then returned from a capture register. Fetches from any other segment go straight to memory and are never stored.

Each word slot keeps its own 24-bit tag, which is the low 24 bits of the word address it holds. A tag of all ones marks the slot empty, so there is no separate valid bit. The array is cleared to all ones, one word per cycle over 1024 cycles, in three cases: after reset, on the reset-style invalidate input, and on the isolate-flush input. Memory writes are not watched, so a hit deliberately returns the code that was fetched earlier, even if memory has since changed.

Top module: `icache_top`

## Requirements
- R1: A fetch whose address bits [31:24] are neither 0x00 nor 0x80 issues exactly one memory read at the fetch address. It returns that word and never allocates, so repeating the fetch reads memory again.
- R2: A cacheable fetch that hits raises fetchReady in the same cycle as fetchValid, returns the stored word and issues no memory read.
- R3: A cacheable miss reads the four words of the 16-byte-aligned line in ascending order (base, base+4, base+8, base+12). fetchReady rises in the cycle after the last acknowledge, with the requested word on fetchData.
- R4: The tag is fetch address bits [23:0] and the word index is bits [11:2]. Two addresses that differ only in the top byte (0x00 against 0x80) share an entry. Two addresses 4096 bytes apart evict each other.
- R5: Once a line has been filled, changes to the memory contents are not seen: a later hit returns the old word.
- R6: After reset, fetchReady and memReq stay low while the array is cleared, which takes at least 1024 cycles. The first cacheable fetch after that misses.
- R7: A one-cycle flushReq pulse forces fetchReady low in that cycle and clears the whole array. fetchReady stays low for at least 1024 cycles afterwards, and the next fetch of a previously cached address misses.
- R8: A one-cycle invReq pulse has the same effect as flushReq: the array is cleared and earlier lines miss.
- R9: flushReq or invReq during a line fill aborts the fill, and memReq is low in the cycle after the pulse. After the clear, the still-pending fetch is served by a fresh fill that returns the current memory word.
- R10: While memReq is high without memAck, memReq and memAddr hold in the next cycle unless a flush or invalidate is asserted. The word is taken from memRdata in the cycle memAck is high.
- R11: fetchReady is high only while fetchValid is high. The CPU holds fetchValid and fetchAddr until fetchReady.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; starts a full clear |
| fetchValid | input | 1 | CPU fetch request |
| fetchAddr | input | 32 | Fetch byte address, word-aligned |
| fetchReady | output | 1 | Opcode on fetchData is valid; the fetch completes this cycle |
| fetchData | output | 32 | Returned opcode |
| flushReq | input | 1 | Isolate-flush pulse; clears the array |
| invReq | input | 1 | Reset-style invalidate pulse; clears the array |
| memReq | output | 1 | Memory word read request |
| memAddr | output | 32 | Memory word address |
| memAck | input | 1 | One-cycle acknowledge; memRdata is valid |
| memRdata | input | 32 | Memory read data |

## Verification
A wrong stored tag or a wrong word index shows up at the ports on the next fetch of that address. The symptom is either a memory read where a zero-wait hit was expected, or a zero-wait answer carrying another address's word. A fill that walks the line wrongly appears in the order of memory addresses at once, within the four acknowledges of that miss. A clear that is too short or never finishes shows up as fetchReady returning before 1024 cycles, or as a previously cached line still hitting after a flush. The sweeps fetch every word slot of the array, so each index and each of the 256 line fills is observed.

// File: rtl/icache_pkg.sv
package icache_pkg;
  localparam int unsigned CACHE_BYTES = 4096;
  localparam int unsigned LINE_BYTES  = 16;
  localparam int unsigned WORD_BYTES  = 4;
  localparam int unsigned TAG_W       = 24;
  localparam int unsigned WORDS       = CACHE_BYTES / WORD_BYTES;
  localparam int unsigned IDX_W       = $clog2(WORDS);
  localparam int unsigned LINE_WORDS  = LINE_BYTES / WORD_BYTES;
  localparam int unsigned OFS_W       = $clog2(LINE_WORDS);
  localparam int unsigned BYTE_W      = $clog2(WORD_BYTES);
  localparam int unsigned LINE_SH     = BYTE_W + OFS_W;

  // strobes from control to datapath
  typedef struct packed {
    logic             fillWr;
    logic             clrWr;
    logic             capture;
    logic             selResp;
    logic             selFill;
    logic [OFS_W-1:0] fillCnt;
    logic [IDX_W-1:0] clrIdx;
  } strobe_t;
endpackage

// File: rtl/icache_datapath.sv
module icache_datapath
  import icache_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter logic [ADDR_W-TAG_W-1:0] SEG_LO = '0,
  parameter logic [ADDR_W-TAG_W-1:0] SEG_HI = '0
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] fetchAddr,
  input  logic [DATA_W-1:0] memRdata,
  input  strobe_t           st,
  output logic              cacheable,
  output logic              hit,
  output logic [DATA_W-1:0] fetchData,
  output logic [ADDR_W-1:0] memAddr
);
  logic [TAG_W-1:0]  tagMem  [WORDS];
  logic [DATA_W-1:0] dataMem [WORDS];
  logic [DATA_W-1:0] respData;

  logic [IDX_W-1:0]        idx;
  logic [IDX_W-1:0]        fillIdx;
  logic [ADDR_W-1:0]       fillAddr;
  logic [TAG_W-1:0]        storedTag;
  logic [ADDR_W-TAG_W-1:0] seg;

  assign idx       = fetchAddr[IDX_W+BYTE_W-1:BYTE_W];
  assign fillIdx   = {fetchAddr[IDX_W+BYTE_W-1:LINE_SH], st.fillCnt};
  assign fillAddr  = {fetchAddr[ADDR_W-1:LINE_SH], st.fillCnt, {BYTE_W{1'b0}}};
  assign seg       = fetchAddr[ADDR_W-1:TAG_W];
  assign cacheable = (seg == SEG_LO) || (seg == SEG_HI);
  assign storedTag = tagMem[idx];
  // all ones means empty
  assign hit       = cacheable && (storedTag != '1) && (storedTag == fetchAddr[TAG_W-1:0]);

  always_ff @(posedge clk) begin
    if (st.clrWr) begin
      tagMem[st.clrIdx]  <= '1;
      dataMem[st.clrIdx] <= '1;
    end else if (st.fillWr) begin
      tagMem[fillIdx]  <= fillAddr[TAG_W-1:0];
      dataMem[fillIdx] <= memRdata;
    end
    if (st.capture) respData <= memRdata;
  end

  assign fetchData = st.selResp ? respData : dataMem[idx];
  assign memAddr   = st.selFill ? fillAddr : fetchAddr;
endmodule

// File: rtl/icache_ctrl.sv
module icache_ctrl
  import icache_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fetchValid,
  input  logic             cacheable,
  input  logic             hit,
  input  logic [OFS_W-1:0] critOfs,
  input  logic             memAck,
  input  logic             flushReq,
  input  logic             invReq,
  output logic             fetchReady,
  output logic             memReq,
  output strobe_t          st
);
  typedef enum logic [2:0] {S_CLEAR, S_IDLE, S_FILL, S_BYP, S_RESP} state_t;

  state_t           state, stateNxt;
  logic [OFS_W-1:0] fillCnt, fillCntNxt;
  logic [IDX_W-1:0] clrIdx, clrIdxNxt;
  logic             wipe;

  assign wipe = flushReq | invReq;

  always_comb begin
    st         = '0;
    st.fillCnt = fillCnt;
    st.clrIdx  = clrIdx;
    fetchReady = 1'b0;
    memReq     = 1'b0;
    stateNxt   = state;
    fillCntNxt = fillCnt;
    clrIdxNxt  = clrIdx;
    unique case (state)
      S_CLEAR: begin
        st.clrWr  = 1'b1;
        clrIdxNxt = clrIdx + 1'b1;
        if (clrIdx == IDX_W'(WORDS - 1)) stateNxt = S_IDLE;
      end
      S_IDLE: begin
        fetchReady = fetchValid && hit && !wipe;
        if (fetchValid && !hit) begin
          fillCntNxt = '0;
          stateNxt   = cacheable ? S_FILL : S_BYP;
        end
      end
      S_FILL: begin
        memReq     = 1'b1;
        st.selFill = 1'b1;
        st.fillWr  = memAck && !wipe;
        st.capture = memAck && !wipe && (fillCnt == critOfs);
        if (memAck) begin
          fillCntNxt = fillCnt + 1'b1;
          if (fillCnt == OFS_W'(LINE_WORDS - 1)) stateNxt = S_RESP;
        end
      end
      S_BYP: begin
        memReq     = 1'b1;
        st.capture = memAck && !wipe;
        if (memAck) stateNxt = S_RESP;
      end
      S_RESP: begin
        st.selResp = 1'b1;
        fetchReady = !wipe;
        stateNxt   = S_IDLE;
      end
      default: stateNxt = S_CLEAR;
    endcase
    if (wipe) begin
      stateNxt  = S_CLEAR;
      clrIdxNxt = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_CLEAR;
      fillCnt <= '0;
      clrIdx  <= '0;
    end else begin
      state   <= stateNxt;
      fillCnt <= fillCntNxt;
      clrIdx  <= clrIdxNxt;
    end
  end
endmodule

// File: rtl/icache_top.sv
module icache_top
  import icache_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter logic [ADDR_W-TAG_W-1:0] SEG_LO = 'h00,
  parameter logic [ADDR_W-TAG_W-1:0] SEG_HI = 'h80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetchValid,
  input  logic [ADDR_W-1:0] fetchAddr,
  output logic              fetchReady,
  output logic [DATA_W-1:0] fetchData,
  input  logic              flushReq,
  input  logic              invReq,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  input  logic              memAck,
  input  logic [DATA_W-1:0] memRdata
);
  strobe_t st;
  logic    cacheable;
  logic    hit;

  icache_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .fetchValid (fetchValid),
    .cacheable  (cacheable),
    .hit        (hit),
    .critOfs    (fetchAddr[LINE_SH-1:BYTE_W]),
    .memAck     (memAck),
    .flushReq   (flushReq),
    .invReq     (invReq),
    .fetchReady (fetchReady),
    .memReq     (memReq),
    .st         (st)
  );

  icache_datapath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .SEG_LO (SEG_LO),
    .SEG_HI (SEG_HI)
  ) u_dp (
    .clk       (clk),
    .fetchAddr (fetchAddr),
    .memRdata  (memRdata),
    .st        (st),
    .cacheable (cacheable),
    .hit       (hit),
    .fetchData (fetchData),
    .memAddr   (memAddr)
  );
endmodule

// File: rtl/icache_checker.sv
module icache_checker
  import icache_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fetchValid,
  input logic [ADDR_W-1:0] fetchAddr,
  input logic              fetchReady,
  input logic              flushReq,
  input logic              invReq,
  input logic              memReq,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memAck
);
  localparam int unsigned GAP_W = IDX_W + 2;
  logic [GAP_W-1:0] gap;
  logic             segCache;

  assign segCache = (fetchAddr[ADDR_W-1:TAG_W] == 'h00) || (fetchAddr[ADDR_W-1:TAG_W] == 'h80);

  // cycles since the last reset, flush or invalidate, saturating
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gap <= '0;
    else if (flushReq || invReq) gap <= '0;
    else if (gap != '1) gap <= gap + 1'b1;
  end

  // R6 R7 R8: no answer before a full clear
  assert_clear_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fetchReady |-> (gap >= GAP_W'(WORDS)));

  // R7 R8: a wipe pulse blocks the answer in its own cycle
  assert_wipe_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flushReq || invReq) |-> !fetchReady);

  // R9: fill aborted after a wipe
  assert_abort_fill_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flushReq || invReq) |=> !memReq);

  // R10: request holds until acknowledged
  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (memReq && !memAck && !flushReq && !invReq) |=> (memReq && $stable(memAddr)));

  // R11: answer only to a pending fetch
  assert_ready_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
    fetchReady |-> fetchValid);

  // R1: outside the cacheable segments memory sees the fetch address itself
  assert_bypass_addr_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (memReq && fetchValid && !segCache) |-> (memAddr == fetchAddr));

  // R3: a fill stays within the requested line
  assert_fill_line_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (memReq && fetchValid && segCache) |->
      (memAddr[ADDR_W-1:LINE_SH] == fetchAddr[ADDR_W-1:LINE_SH]));
endmodule

bind icache_top icache_checker #(.ADDR_W(ADDR_W)) u_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .fetchValid (fetchValid),
  .fetchAddr  (fetchAddr),
  .fetchReady (fetchReady),
  .flushReq   (flushReq),
  .invReq     (invReq),
  .memReq     (memReq),
  .memAddr    (memAddr),
  .memAck     (memAck)
);

// File: tb/tb_icache_top.sv
`timescale 1ns/1ps
module tb_icache_top;
  localparam int LAT = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fetchValid = 1'b0;
  logic [31:0] fetchAddr = '0;
  logic        fetchReady;
  logic [31:0] fetchData;
  logic        flushReq = 1'b0;
  logic        invReq = 1'b0;
  logic        memReq;
  logic [31:0] memAddr;
  logic        memAck = 1'b0;
  logic [31:0] memRdata = '0;

  int          checks = 0;
  int          errors = 0;
  int          ver = 0;
  int          ackCount = 0;
  logic [31:0] ackLog [8];
  int          waitCnt = 0;
  int          memWait = 0;
  int          cycles = 0;

  always #2.5 clk = ~clk;

  icache_top dut (
    .clk(clk), .rst_n(rst_n), .fetchValid(fetchValid), .fetchAddr(fetchAddr),
    .fetchReady(fetchReady), .fetchData(fetchData), .flushReq(flushReq),
    .invReq(invReq), .memReq(memReq), .memAddr(memAddr), .memAck(memAck),
    .memRdata(memRdata)
  );

  function automatic logic [31:0] memWord(input logic [31:0] a, input int v);
    return ({a[31:2], 2'b00} * 32'h9E37_79B1) + 32'(v) * 32'h0101_0101;
  endfunction

  // memory model: acknowledge LAT cycles after the request is seen
  always @(posedge clk) begin
    if (!memReq || memAck) begin
      memAck  <= 1'b0;
      memWait <= 0;
    end else if (memWait == LAT) begin
      memAck   <= 1'b1;
      memRdata <= memWord(memAddr, ver);
      if (ackCount < 8) ackLog[ackCount] <= memAddr;
      ackCount <= ackCount + 1;
    end else begin
      memWait <= memWait + 1;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // runs one fetch; leaves the clock at the negedge after the transfer
  task automatic doFetch(input logic [31:0] a, output logic [31:0] data);
    ackCount   = 0;
    waitCnt    = 0;
    fetchAddr  = a;
    fetchValid = 1'b1;
    forever begin
      #1;
      if (fetchReady) break;
      @(negedge clk);
      waitCnt++;
    end
    data = fetchData;
    @(negedge clk);
    fetchValid = 1'b0;
  endtask

  task automatic pulse(input bit isFlush);
    @(negedge clk);
    if (isFlush) flushReq = 1'b1; else invReq = 1'b1;
    #1;
    check(fetchReady == 1'b0, isFlush ? "R7" : "R8", "ready in pulse cycle", 32'(fetchReady), 0);
    @(negedge clk);
    flushReq = 1'b0;
    invReq   = 1'b0;
  endtask

  task automatic checkLine(input logic [31:0] a, input string req);
    check(ackCount == 4, req, "line fill reads", 32'(ackCount), 4);
    for (int k = 0; k < 4; k++)
      check(ackLog[k] == {a[31:4], 4'h0} + 32'(4 * k), "R3", "fill order", ackLog[k],
            {a[31:4], 4'h0} + 32'(4 * k));
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 190000) begin
        errors++;
        $display("FAIL R11 watchdog actual=%0d expected=done", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    check(fetchReady == 1'b0 && memReq == 1'b0, "R6", "outputs in reset",
          {fetchReady, memReq}, 0);
    rst_n = 1'b1;
    fetchAddr  = 32'h0;
    fetchValid = 1'b1;
    @(negedge clk);
    check(memReq == 1'b0 && fetchReady == 1'b0, "R6", "quiet during clear",
          {fetchReady, memReq}, 0);
    doFetch(32'h0, d);
    check(waitCnt >= 1024, "R6", "clear length", waitCnt, 1024);
    checkLine(32'h0, "R6");
    check(d == memWord(32'h0, 0), "R3", "first fetch data", d, memWord(32'h0, 0));

    // sweep every word slot: one fill per line, hits after
    for (int i = 0; i < 1024; i++) begin
      logic [31:0] a;
      a = 32'(i * 4);
      doFetch(a, d);
      check(d == memWord(a, 0), "R3", "sweep data", d, memWord(a, 0));
      if (i % 4 == 0 && i != 0) checkLine(a, "R3");
      else begin
        check(ackCount == 0, "R2", "hit reads memory", ackCount, 0);
        check(waitCnt == 0, "R2", "hit wait", waitCnt, 0);
      end
    end

    // memory changes; hits keep the old code
    ver = 1;
    for (int i = 0; i < 1024; i++) begin
      logic [31:0] a;
      a = 32'(i * 4);
      doFetch(a, d);
      check(d == memWord(a, 0), "R5", "stale hit data", d, memWord(a, 0));
      check(ackCount == 0 && waitCnt == 0, "R2", "second sweep hit", ackCount + waitCnt, 0);
    end

    // R11: no answer without a request
    fetchAddr = 32'h4;
    fetchValid = 1'b0;
    @(negedge clk);
    #1;
    check(fetchReady == 1'b0 && memReq == 1'b0, "R11", "idle without valid",
          {fetchReady, memReq}, 0);

    // R4: 0x80 segment shares entries with 0x00
    doFetch(32'h8000_0010, d);
    check(d == memWord(32'h10, 0) && ackCount == 0, "R4", "segment alias", d, memWord(32'h10, 0));

    // R1: bypass, twice, never stored
    for (int r = 0; r < 2; r++) begin
      doFetch(32'hA000_0010, d);
      check(ackCount == 1 && ackLog[0] == 32'hA000_0010, "R1", "bypass read", ackLog[0], 32'hA000_0010);
      check(d == memWord(32'hA000_0010, 1), "R1", "bypass data", d, memWord(32'hA000_0010, 1));
    end
    doFetch(32'h1F00_0020, d);
    check(ackCount == 1 && d == memWord(32'h1F00_0020, 1), "R1", "io bypass", d,
          memWord(32'h1F00_0020, 1));

    // R4: 4 KB apart evicts
    doFetch(32'h0000_1008, d);
    checkLine(32'h0000_1008, "R4");
    check(d == memWord(32'h1008, 1), "R4", "evicting data", d, memWord(32'h1008, 1));
    doFetch(32'h0000_0004, d);
    checkLine(32'h0000_0004, "R4");
    check(d == memWord(32'h4, 1), "R4", "evicted refill", d, memWord(32'h4, 1));

    // R7: flush
    pulse(1'b1);
    doFetch(32'h100, d);
    check(waitCnt >= 1023, "R7", "flush clear length", waitCnt, 1023);
    checkLine(32'h100, "R7");
    check(d == memWord(32'h100, 1), "R7", "after flush data", d, memWord(32'h100, 1));

    // R8: invalidate
    ver = 2;
    pulse(1'b0);
    doFetch(32'h104, d);
    check(waitCnt >= 1023, "R8", "invalidate clear length", waitCnt, 1023);
    checkLine(32'h104, "R8");
    check(d == memWord(32'h104, 2), "R8", "after invalidate data", d, memWord(32'h104, 2));

    // R9: flush in the middle of a fill
    fetchAddr  = 32'h2008;
    fetchValid = 1'b1;
    repeat (3) @(negedge clk);
    check(memReq == 1'b1, "R9", "fill in progress", 32'(memReq), 1);
    flushReq = 1'b1;
    @(negedge clk);
    flushReq = 1'b0;
    check(memReq == 1'b0, "R9", "fill aborted", 32'(memReq), 0);
    ver = 3;
    doFetch(32'h2008, d);
    check(waitCnt >= 1023, "R9", "clear after abort", waitCnt, 1023);
    checkLine(32'h2008, "R9");
    check(d == memWord(32'h2008, 3), "R9", "refetched data", d, memWord(32'h2008, 3));
    // R10: acknowledged addresses matched the held request
    check(ackLog[2] == 32'h2008, "R10", "held address", ackLog[2], 32'h2008);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule